// File: doc/BRIEF.md
# Pseudo-Random Sequence Generator with Seed Loading and Continuity Flag

This block generates a pseudo-random sequence with an N-bit linear feedback shift register. At build time it takes one of two gate arrangements: a Fibonacci arrangement, where the tap outputs are combined back into bit 0, or a Galois arrangement, where the MSB is folded into the gates between stages. The feedback gate can be an exclusive-OR or an exclusive-NOR. At run time the generator can be stepped, frozen by an enable, reloaded with a fixed value on a clock edge, cleared asynchronously to a fixed value, or given a new seed. A build parameter selects how the seed arrives: as a whole word in one edge, or one bit per edge.

Two status outputs follow the generator. `seq_ok` is high only when the value now on the outputs is the direct successor of the value shown before it. `seed_done` marks the cycle in which a seed has just been fully written. A consumer that also accepts fresh seeds as usable data can take the OR of the two flags. When the consumer reads only the serial bit of a Fibonacci generator, a bit-serial seed is handled as a pseudo-parallel load. The bits already in the register keep leaving in order while the seed enters, so `seq_ok` stays high until the final seed bit goes in.

All control pins are plain level inputs sampled on the rising edge. The block has no handshake: the generator has no stall condition, and freezing is the job of `step_en`.

Top module: `pn_seed_gen`

## Requirements
- R1: While `rst_async` is high, the register holds ARST_VAL and `seq_ok` and `seed_done` are low, at once and with no clock edge needed.
- R2: On an edge with `step_en`=1 and `reseed_sync`=0 and `seed_wr`=0, the register takes one generator step. Fibonacci: the bits move one place toward the MSB, and bit 0 becomes the parity of the bits selected by TAPS, inverted when FB_XNOR=1. Galois: bit 0 becomes the old MSB, and each bit i≥1 becomes old bit i-1, XORed with the old MSB and with FB_XNOR where TAPS[i]=1. `rnd_bit` is always the MSB of `rnd_word`.
- R3: After a stepping edge `seq_ok` is 1 and `seed_done` is 0, unless R10 applies.
- R4: An edge with `step_en`=0 (and `reseed_sync`=0) leaves the register and the serial bit count unchanged and drives `seq_ok` and `seed_done` low.
- R5: An edge with `reseed_sync`=1 loads SRST_VAL and drives both flags low, whatever `step_en` and `seed_wr` are. It also discards any partially shifted seed.
- R6: Word load (LOAD_MODE=PN_LD_PAR): an edge with `seed_wr`=1 and `step_en`=1 writes `seed_word` into the register, and `seed_done`=1 and `seq_ok`=0 for that one cycle. `seed_bit` is ignored.
- R7: Bit-serial load (LOAD_MODE=PN_LD_SER): each edge with `seed_wr`=1 and `step_en`=1 moves the register one place toward the MSB and puts `seed_bit` into bit 0. The N-th such bit completes the seed: for that cycle `seed_done`=1 and `seq_ok`=0, and counting starts again from zero. `seed_word` is ignored.
- R8: Pseudo-parallel case (Fibonacci, bit-serial load, STREAM_SERIAL=1): `seq_ok` is 1 after each seed bit before the N-th.
- R9: Other bit-serial builds (Galois, or STREAM_SERIAL=0): `seq_ok` is 0 after every seed bit, from the first bit until the seed is complete.
- R10: If a bit-serial load stops early (a stepping edge while the bit count is non-zero), that edge still steps the register, but `seq_ok` stays 0 for that cycle. The count clears, so a later load again needs N bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_async | input | 1 | Asynchronous reset to ARST_VAL, active high |
| step_en | input | 1 | Clock enable for stepping and loading |
| reseed_sync | input | 1 | Synchronous reload of SRST_VAL |
| seed_wr | input | 1 | Seed write strobe (held for N edges in bit-serial mode) |
| seed_bit | input | 1 | Seed bit, bit-serial mode, MSB first |
| seed_word | input | N | Seed word, word-load mode |
| rnd_bit | output | 1 | Serial sequence output (register MSB) |
| rnd_word | output | N | Parallel register contents |
| seq_ok | output | 1 | Output is the direct successor of the previous output |
| seed_done | output | 1 | A seed has just been completely written |

## Verification
A wrong serial bit count shows up at the ports as `seed_done` pulsing on the wrong edge, one edge early or late, and also as a `rnd_word` at completion that does not equal the shifted pattern. The pseudo-parallel and Galois builds are run side by side through the same bit stream so that the mid-load `seq_ok` policy is seen to differ. A flag that is not cleared after a freeze, a reload or an early-stopped load is seen as `seq_ok` high one cycle after the event. A wrong step function or tap decode makes `rnd_word` differ from the independently computed sequence at the first step after reset.

// File: rtl/pn_pkg.sv
package pn_pkg;
  typedef enum logic {PN_FIB, PN_GAL} pn_arch_e;
  typedef enum logic {PN_LD_PAR, PN_LD_SER} pn_load_e;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_RUN   = 3'd1,
    OP_PLOAD = 3'd2,
    OP_SHIFT = 3'd3,
    OP_RSYNC = 3'd4
  } pn_op_e;
endpackage

// File: rtl/pn_lfsr_step.sv
module pn_lfsr_step
  import pn_pkg::*;
#(
  parameter int       N       = 8,
  parameter logic [N-1:0] TAPS = 8'hB8,
  parameter pn_arch_e ARCH    = PN_FIB,
  parameter bit       FB_XNOR = 1'b0
) (
  input  logic [N-1:0] cur,
  output logic [N-1:0] nxt
);
  generate
    if (ARCH == PN_FIB) begin : g_fib
      logic fb;
      assign fb  = (^(cur & TAPS)) ^ FB_XNOR;
      assign nxt = {cur[N-2:0], fb};
    end else begin : g_gal
      logic fb;
      assign fb     = cur[N-1];
      assign nxt[0] = fb;
      for (genvar i = 1; i < N; i++) begin : g_stage
        if (TAPS[i]) begin : g_gate
          assign nxt[i] = cur[i-1] ^ fb ^ FB_XNOR;
        end else begin : g_wire
          assign nxt[i] = cur[i-1];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pn_load_track.sv
module pn_load_track
  import pn_pkg::*;
#(
  parameter int       N             = 8,
  parameter pn_load_e LOAD_MODE     = PN_LD_PAR,
  parameter pn_arch_e ARCH          = PN_FIB,
  parameter bit       STREAM_SERIAL = 1'b0
) (
  input  logic   clk,
  input  logic   rst_async,
  input  logic   step_en,
  input  logic   reseed_sync,
  input  logic   seed_wr,
  output pn_op_e op,
  output logic   seq_ok,
  output logic   seed_done
);
  localparam int CW = $clog2(N + 1);
  localparam bit PSEUDO = (LOAD_MODE == PN_LD_SER) && (ARCH == PN_FIB) && STREAM_SERIAL;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] bit_cnt;
  logic          last_bit;

  always_comb begin
    if (reseed_sync)   op = OP_RSYNC;
    else if (!step_en) op = OP_HOLD;
    else if (seed_wr)  op = (LOAD_MODE == PN_LD_PAR) ? OP_PLOAD : OP_SHIFT;
    else               op = OP_RUN;
  end

  assign last_bit = (bit_cnt == LAST);

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      bit_cnt   <= '0;
      seq_ok    <= 1'b0;
      seed_done <= 1'b0;
    end else begin
      case (op)
        OP_RSYNC: begin
          bit_cnt   <= '0;
          seq_ok    <= 1'b0;
          seed_done <= 1'b0;
        end
        OP_HOLD: begin
          seq_ok    <= 1'b0;
          seed_done <= 1'b0;
        end
        OP_PLOAD: begin
          bit_cnt   <= '0;
          seq_ok    <= 1'b0;
          seed_done <= 1'b1;
        end
        OP_SHIFT: begin
          if (last_bit) begin
            bit_cnt   <= '0;
            seq_ok    <= 1'b0;
            seed_done <= 1'b1;
          end else begin
            bit_cnt   <= bit_cnt + CW'(1);
            seq_ok    <= PSEUDO;
            seed_done <= 1'b0;
          end
        end
        default: begin
          bit_cnt   <= '0;
          seq_ok    <= (bit_cnt == '0);
          seed_done <= 1'b0;
        end
      endcase
    end
  end

  // R7
  seed_flag_chk: assert property (@(posedge clk) disable iff (rst_async)
    seed_done |-> !seq_ok);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst_async)
    (step_en && !reseed_sync && !seed_wr && bit_cnt != '0) |=> (!seq_ok && bit_cnt == '0));

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst_async)
    bit_cnt <= LAST);
endmodule

// File: rtl/pn_seed_gen.sv
module pn_seed_gen
  import pn_pkg::*;
#(
  parameter int           N             = 8,
  parameter logic [N-1:0] TAPS          = 8'hB8,
  parameter pn_arch_e     ARCH          = PN_FIB,
  parameter bit           FB_XNOR       = 1'b0,
  parameter pn_load_e     LOAD_MODE     = PN_LD_PAR,
  parameter bit           STREAM_SERIAL = 1'b0,
  parameter logic [N-1:0] ARST_VAL      = 8'h01,
  parameter logic [N-1:0] SRST_VAL      = 8'h80
) (
  input  logic         clk,
  input  logic         rst_async,
  input  logic         step_en,
  input  logic         reseed_sync,
  input  logic         seed_wr,
  input  logic         seed_bit,
  input  logic [N-1:0] seed_word,
  output logic         rnd_bit,
  output logic [N-1:0] rnd_word,
  output logic         seq_ok,
  output logic         seed_done
);
  logic [N-1:0] state_q;
  logic [N-1:0] step_val;
  pn_op_e       op;

  pn_lfsr_step #(.N(N), .TAPS(TAPS), .ARCH(ARCH), .FB_XNOR(FB_XNOR)) u_step (
    .cur (state_q),
    .nxt (step_val)
  );

  pn_load_track #(.N(N), .LOAD_MODE(LOAD_MODE), .ARCH(ARCH), .STREAM_SERIAL(STREAM_SERIAL)) u_track (
    .clk         (clk),
    .rst_async   (rst_async),
    .step_en     (step_en),
    .reseed_sync (reseed_sync),
    .seed_wr     (seed_wr),
    .op          (op),
    .seq_ok      (seq_ok),
    .seed_done   (seed_done)
  );

  always_ff @(posedge clk or posedge rst_async) begin
    if (rst_async) begin
      state_q <= ARST_VAL;
    end else begin
      case (op)
        OP_RSYNC: state_q <= SRST_VAL;
        OP_HOLD:  state_q <= state_q;
        OP_PLOAD: state_q <= seed_word;
        OP_SHIFT: state_q <= {state_q[N-2:0], seed_bit};
        default:  state_q <= step_val;
      endcase
    end
  end

  assign rnd_word = state_q;
  assign rnd_bit  = state_q[N-1];

  // R4
  freeze_chk: assert property (@(posedge clk) disable iff (rst_async)
    (!step_en && !reseed_sync) |=> ($stable(rnd_word) && !seq_ok && !seed_done));

  // R5
  rsync_chk: assert property (@(posedge clk) disable iff (rst_async)
    reseed_sync |=> (rnd_word == SRST_VAL && !seq_ok && !seed_done));

  generate
    if (LOAD_MODE == PN_LD_PAR) begin : g_par_chk
      // R6
      word_load_chk: assert property (@(posedge clk) disable iff (rst_async)
        (seed_wr && step_en && !reseed_sync) |=>
          (rnd_word == $past(seed_word) && seed_done && !seq_ok));
    end else begin : g_ser_chk
      // R7
      bit_shift_chk: assert property (@(posedge clk) disable iff (rst_async)
        (seed_wr && step_en && !reseed_sync) |=>
          (rnd_word[0] == $past(seed_bit) && rnd_word[N-1:1] == $past(rnd_word[N-2:0])));
    end
  endgenerate
endmodule

// File: tb/pn_seed_gen_bench.sv
module pn_seed_gen_bench;
  import pn_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] TP   = 8'hB8;
  localparam logic [7:0] AVAL = 8'h01;
  localparam logic [7:0] SVAL = 8'h80;
  // instance configs: 0 word-load Fibonacci XOR, 1 bit-serial Fibonacci serial stream, 2 bit-serial Galois XNOR
  localparam bit CF_GAL [3]    = '{1'b0, 1'b0, 1'b1};
  localparam bit CF_XN  [3]    = '{1'b0, 1'b0, 1'b1};
  localparam bit CF_PAR [3]    = '{1'b1, 1'b0, 1'b0};
  localparam bit CF_PSEUDO [3] = '{1'b0, 1'b1, 1'b0};

  logic clk = 1'b0;
  logic rst_async = 1'b1;
  logic step_en = 1'b1;
  logic reseed_sync = 1'b0;
  logic       ld  [3];
  logic       sdi [3];
  logic [7:0] pdi [3];
  logic       o_sd [3];
  logic [7:0] o_pd [3];
  logic       o_ok [3];
  logic       o_ns [3];

  logic [7:0] m_st  [3];
  logic       m_ok  [3];
  logic       m_ns  [3];
  int         m_cnt [3];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_seed_gen #(.ARCH(PN_FIB), .FB_XNOR(1'b0), .LOAD_MODE(PN_LD_PAR), .STREAM_SERIAL(1'b0)) u_pn_seed_gen (
    .clk(clk), .rst_async(rst_async), .step_en(step_en), .reseed_sync(reseed_sync),
    .seed_wr(ld[0]), .seed_bit(sdi[0]), .seed_word(pdi[0]),
    .rnd_bit(o_sd[0]), .rnd_word(o_pd[0]), .seq_ok(o_ok[0]), .seed_done(o_ns[0]));

  pn_seed_gen #(.ARCH(PN_FIB), .FB_XNOR(1'b0), .LOAD_MODE(PN_LD_SER), .STREAM_SERIAL(1'b1)) u_pn_seed_gen_ser (
    .clk(clk), .rst_async(rst_async), .step_en(step_en), .reseed_sync(reseed_sync),
    .seed_wr(ld[1]), .seed_bit(sdi[1]), .seed_word(pdi[1]),
    .rnd_bit(o_sd[1]), .rnd_word(o_pd[1]), .seq_ok(o_ok[1]), .seed_done(o_ns[1]));

  pn_seed_gen #(.ARCH(PN_GAL), .FB_XNOR(1'b1), .LOAD_MODE(PN_LD_SER), .STREAM_SERIAL(1'b0)) u_pn_seed_gen_gal (
    .clk(clk), .rst_async(rst_async), .step_en(step_en), .reseed_sync(reseed_sync),
    .seed_wr(ld[2]), .seed_bit(sdi[2]), .seed_word(pdi[2]),
    .rnd_bit(o_sd[2]), .rnd_word(o_pd[2]), .seq_ok(o_ok[2]), .seed_done(o_ns[2]));

  // generator step as defined in R2
  function automatic logic [7:0] ref_step(logic [7:0] s, bit gal, bit xn);
    logic [7:0] r;
    if (!gal) begin
      r = {s[6:0], (^(s & TP)) ^ xn};
    end else begin
      r[0] = s[7];
      for (int i = 1; i < 8; i++) r[i] = TP[i] ? (s[i-1] ^ s[7] ^ xn) : s[i-1];
    end
    return r;
  endfunction

  // reference model of R1..R10
  always @(posedge clk or posedge rst_async) begin
    for (int k = 0; k < 3; k++) begin
      if (rst_async) begin
        m_st[k] <= AVAL; m_ok[k] <= 1'b0; m_ns[k] <= 1'b0; m_cnt[k] <= 0;
      end else if (reseed_sync) begin
        m_st[k] <= SVAL; m_ok[k] <= 1'b0; m_ns[k] <= 1'b0; m_cnt[k] <= 0;
      end else if (!step_en) begin
        m_ok[k] <= 1'b0; m_ns[k] <= 1'b0;
      end else if (ld[k]) begin
        if (CF_PAR[k]) begin
          m_st[k] <= pdi[k]; m_ok[k] <= 1'b0; m_ns[k] <= 1'b1; m_cnt[k] <= 0;
        end else begin
          m_st[k] <= {m_st[k][6:0], sdi[k]};
          if (m_cnt[k] == 7) begin
            m_cnt[k] <= 0; m_ok[k] <= 1'b0; m_ns[k] <= 1'b1;
          end else begin
            m_cnt[k] <= m_cnt[k] + 1; m_ok[k] <= CF_PSEUDO[k]; m_ns[k] <= 1'b0;
          end
        end
      end else begin
        m_st[k] <= ref_step(m_st[k], CF_GAL[k], CF_XN[k]);
        m_ok[k] <= (m_cnt[k] == 0); m_ns[k] <= 1'b0; m_cnt[k] <= 0;
      end
    end
  end

  task automatic check_all(input string req);
    for (int k = 0; k < 3; k++) begin
      checks++;
      if ({o_sd[k], o_pd[k], o_ok[k], o_ns[k]} !== {m_st[k][7], m_st[k], m_ok[k], m_ns[k]}) begin
        errors++;
        $display("FAIL %s inst%0d: actual bit=%b word=%h ok=%b done=%b expected bit=%b word=%h ok=%b done=%b",
                 req, k, o_sd[k], o_pd[k], o_ok[k], o_ns[k], m_st[k][7], m_st[k], m_ok[k], m_ns[k]);
      end
    end
  endtask

  task automatic expect_val(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic edge_chk(input string req);
    @(posedge clk);
    @(negedge clk);
    check_all(req);
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    check_all("R1");
    expect_val("R1 reset word", o_pd[0], AVAL);
    expect_val("R1 reset flags", {7'd0, o_ok[0] | o_ns[0]}, 8'h00);
    rst_async = 1'b0;
  endtask

  task automatic t_run;
    edge_chk("R2");
    expect_val("R2 first step", o_pd[0], 8'h02);
    expect_val("R3 valid after step", {7'd0, o_ok[0]}, 8'h01);
    for (int i = 0; i < 10; i++) edge_chk("R2 R3");
  endtask

  task automatic t_freeze;
    step_en = 1'b0;
    edge_chk("R4");
    expect_val("R4 valid drops", {7'd0, o_ok[0]}, 8'h00);
    edge_chk("R4");
    step_en = 1'b1;
    edge_chk("R3 resume");
  endtask

  task automatic t_word_load;
    ld[0] = 1'b1; pdi[0] = 8'h3C;
    sdi[0] = 1'b1;
    edge_chk("R6");
    expect_val("R6 seed word", o_pd[0], 8'h3C);
    expect_val("R6 flags", {6'd0, o_ok[0], o_ns[0]}, 8'h01);
    ld[0] = 1'b0;
    edge_chk("R6 after");
    expect_val("R6 valid back", {6'd0, o_ok[0], o_ns[0]}, 8'h02);
  endtask

  task automatic t_serial(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      ld[1] = 1'b1; ld[2] = 1'b1; sdi[1] = v[i]; sdi[2] = v[i];
      pdi[1] = 8'hFF; pdi[2] = 8'hFF;
      edge_chk("R7");
      if (i != 0) begin
        expect_val("R8 mid-load valid", {7'd0, o_ok[1]}, 8'h01);
        expect_val("R9 mid-load valid", {7'd0, o_ok[2]}, 8'h00);
      end
    end
    expect_val("R7 serial seed", o_pd[1], v);
    expect_val("R7 serial seed gal", o_pd[2], v);
    expect_val("R7 completion flags", {6'd0, o_ok[1], o_ns[1]}, 8'h01);
    ld[1] = 1'b0; ld[2] = 1'b0;
    edge_chk("R7 after");
    expect_val("R3 valid after seed", {7'd0, o_ok[2]}, 8'h01);
  endtask

  task automatic t_serial_pause;
    for (int i = 0; i < 4; i++) begin ld[2] = 1'b1; sdi[2] = i[0]; edge_chk("R7 pause"); end
    step_en = 1'b0;
    edge_chk("R4 pause");
    step_en = 1'b1;
    for (int i = 0; i < 4; i++) begin ld[2] = 1'b1; sdi[2] = 1'b1; edge_chk("R7 pause"); end
    expect_val("R7 paused seed", o_pd[2], 8'h5F);
    expect_val("R7 paused done", {7'd0, o_ns[2]}, 8'h01);
    ld[2] = 1'b0;
    edge_chk("R3");
  endtask

  task automatic t_abort;
    for (int i = 0; i < 3; i++) begin ld[1] = 1'b1; ld[2] = 1'b1; sdi[1] = 1'b1; sdi[2] = 1'b0; edge_chk("R10"); end
    ld[1] = 1'b0; ld[2] = 1'b0;
    edge_chk("R10 abort");
    expect_val("R10 abort valid", {6'd0, o_ok[1], o_ok[2]}, 8'h00);
    edge_chk("R10 after");
    expect_val("R10 valid back", {6'd0, o_ok[1], o_ok[2]}, 8'h03);
    for (int i = 0; i < 7; i++) begin
      ld[1] = 1'b1; sdi[1] = 1'b0; edge_chk("R10 reload");
      expect_val("R10 no early done", {7'd0, o_ns[1]}, 8'h00);
    end
    sdi[1] = 1'b1;
    edge_chk("R10 reload");
    expect_val("R10 full count", o_pd[1], 8'h01);
    ld[1] = 1'b0;
    edge_chk("R10");
  endtask

  task automatic t_reseed;
    for (int i = 0; i < 3; i++) begin ld[1] = 1'b1; sdi[1] = 1'b1; edge_chk("R5 pre"); end
    reseed_sync = 1'b1; step_en = 1'b0;
    edge_chk("R5");
    expect_val("R5 constant", o_pd[1], SVAL);
    expect_val("R5 constant par", o_pd[0], SVAL);
    reseed_sync = 1'b0; step_en = 1'b1;
    for (int i = 0; i < 8; i++) begin sdi[1] = i[0]; edge_chk("R5 restart"); end
    expect_val("R5 fresh count", {7'd0, o_ns[1]}, 8'h01);
    ld[1] = 1'b0;
    edge_chk("R5");
  endtask

  task automatic t_async;
    edge_chk("R2");
    rst_async = 1'b1;
    #1;
    check_all("R1 async");
    expect_val("R1 async word", o_pd[2], AVAL);
    expect_val("R1 async valid", {5'd0, o_ok[0], o_ok[1], o_ok[2]}, 8'h00);
    @(negedge clk);
    rst_async = 1'b0;
    edge_chk("R3 after reset");
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin ld[k] = 1'b0; sdi[k] = 1'b0; pdi[k] = 8'h00; end
    t_reset;
    t_run;
    t_freeze;
    t_word_load;
    t_serial(8'hA5);
    t_serial(8'h3B);
    t_serial_pause;
    t_abort;
    t_reseed;
    t_async;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule